// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a processor. Each line can be set to latch on a rising edge or to follow its input level. A mask register blocks individual lines. An in-service register records which lines are being handled. A three-bit rotation offset picks which line currently has top priority: the line at the offset ranks first and the ranks then rise around the ring. The output is recomputed combinationally from the registered state, so it reflects every command, mask write, acknowledge and request change one clock after that event.

The processor writes through a small port. Address 0 takes commands: initialize, the end-of-interrupt variants and set-priority. Address 1 takes data, which loads either the mask or the vector base, depending on the controller state. Address 2 takes the edge/level select. An acknowledge strobe returns a vector built from the stored base and the winning line, and marks that line in service. A poll strobe returns the winning line and retires it without a vector cycle.

The command port drives a two-state machine. `ST_RUN` is the normal state. An initialize command (T_INIT) moves it to `ST_WAIT_BASE`, and another initialize command keeps it there (T_REINIT). The next data write stores the vector base and returns it to `ST_RUN` (T_BASE).

Top module: `rotpic_top`

## Requirements
- R1: After reset, the interrupt output, ack_valid and poll_data are 0. Mask, request, in-service, rotation offset, vector base and edge/level select are all 0, so every line is edge-triggered and line 0 ranks first.
- R2: An edge-triggered line sets its request bit on a 0-to-1 change of its input. A line held high after its request is retired does not raise a new request.
- R3: For a line whose select bit is 1 (level mode), the request bit follows the input one clock later. An acknowledge does not clear it.
- R4: In `ST_RUN`, a data write loads the mask. Mask bit n = 1 blocks line n, and the interrupt output reflects the new mask one cycle after the write.
- R5: The interrupt output is 1 exactly when some unmasked request ranks strictly above every in-service line. The rank of line n is (n − offset) mod 8, and rank 0 is the highest.
- R6: When ack_req is high and a request qualifies as in R5, the next cycle gives ack_valid = 1 and ack_vec = {base[7:3], line}. That line's in-service bit is set, and its request bit is cleared only if the line is edge-triggered.
- R7: An ack_req with no qualifying request gives ack_vec = {base[7:3], 3'd7} and changes no in-service bit.
- R8: Command byte 8'b011_00_nnn (specific end of interrupt) clears in-service bit nnn and leaves the offset unchanged.
- R9: Command byte 8'b111_00_nnn clears in-service bit nnn and sets the offset to (nnn + 1) mod 8.
- R10: Command byte 8'b001_00_xxx clears the highest-ranked in-service bit and keeps the offset. Command byte 8'b101_00_xxx clears that bit and sets the offset to (that line + 1) mod 8.
- R11: Command byte 8'b110_00_nnn sets the offset to (nnn + 1) mod 8, which makes line nnn the lowest priority.
- R12: A poll_rd strobe updates poll_data on the next cycle. If a request qualifies, poll_data is {1'b1, 4'b0, line} and both the request bit and the in-service bit of that line are cleared. Otherwise poll_data is 8'h07.
- R13: A command byte with bit 4 = 1 clears the mask, request bits, in-service bits and offset, but keeps the edge/level select. The next data write stores bits 7..3 as the vector base (T_BASE), and later data writes load the mask again.
- R14: A write to address 2 loads the edge/level select register. Bit n = 1 puts line n in level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 command, 1 data, 2 edge/level select, 3 unused |
| wr_data | input | 8 | Write data |
| ack_req | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Vector valid, one cycle after ack_req |
| ack_vec | output | 8 | Acknowledge vector |
| poll_rd | input | 1 | Poll strobe |
| poll_data | output | 8 | Poll result |
| int_out | output | 1 | Interrupt output |

## Verification
The hardest state to reach is a rotated offset with several requests pending. Ranking then depends on the offset and not on line number, and the register holding the offset is only visible through which line wins. The bench first drives each offset 0..7 through set-priority. It then applies a family of computed request patterns, acknowledges the winner and retires it. Finally it drains the rest by polling, so the full rank order is observed and compared with a ring walk computed in the bench. Directed sequences put nested in-service lines and both rotating end-of-interrupt forms in front of pending requests. They choose line pairs whose winner differs depending on whether the offset moved.

// File: rtl/rotpic_pkg.sv
package rotpic_pkg;

    typedef enum logic [1:0] {
        PORT_CMD  = 2'd0,
        PORT_DATA = 2'd1,
        PORT_TRIG = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

    typedef enum logic {
        ST_RUN       = 1'b0,
        ST_WAIT_BASE = 1'b1
    } state_e;

    // decoded write, one flag per action
    typedef struct packed {
        logic init;
        logic data;
        logic trig;
        logic eoi_spec;
        logic eoi_ns;
        logic rotate;
        logic set_pri;
    } cmd_t;

endpackage

// File: rtl/rotpic_cmd_dec.sv
module rotpic_cmd_dec
    import rotpic_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 3
) (
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output cmd_t          cmd,
    output logic [LW-1:0] cmd_line
);
    logic [2:0] op;
    assign op       = wr_data[DW-1:DW-3];
    assign cmd_line = wr_data[LW-1:0];

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            unique case (port_e'(wr_addr))
                PORT_CMD: begin
                    if (wr_data[DW-4]) begin
                        cmd.init = 1'b1;
                    end else if (!wr_data[DW-5]) begin
                        case (op)
                            3'b001: cmd.eoi_ns = 1'b1;
                            3'b011: cmd.eoi_spec = 1'b1;
                            3'b101: begin
                                cmd.eoi_ns = 1'b1;
                                cmd.rotate = 1'b1;
                            end
                            3'b111: begin
                                cmd.eoi_spec = 1'b1;
                                cmd.rotate   = 1'b1;
                            end
                            3'b110: cmd.set_pri = 1'b1;
                            default: ;
                        endcase
                    end
                end
                PORT_DATA: cmd.data = 1'b1;
                PORT_TRIG: cmd.trig = 1'b1;
                PORT_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/rotpic_capture.sv
module rotpic_capture #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] level_sel,
    input  logic [NLINES-1:0] clr,
    input  logic              flush,
    output logic [NLINES-1:0] irr_q
);
    logic [NLINES-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic nx;
        always_comb begin
            if (flush)             nx = 1'b0;
            else if (level_sel[i]) nx = irq_in[i];
            else                   nx = (irr_q[i] & ~clr[i]) | (irq_in[i] & ~prev_q[i]);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irr_q[i] <= 1'b0;
            else        irr_q[i] <= nx;
        end
    end
endmodule

// File: rtl/rotpic_resolver.sv
module rotpic_resolver #(
    parameter int NLINES = 8,
    parameter int LW     = 3
) (
    input  logic [NLINES-1:0] vec,
    input  logic [LW-1:0]     base_off,
    output logic              hit,
    output logic [LW-1:0]     line,
    output logic [LW-1:0]     rank
);
    logic [LW-1:0] idx;

    // walk the ring from the lowest rank so the last match kept is rank-first
    always_comb begin
        hit  = 1'b0;
        line = '0;
        rank = '0;
        idx  = '0;
        for (int k = NLINES - 1; k >= 0; k--) begin
            idx = base_off + LW'(k);
            if (vec[idx]) begin
                hit  = 1'b1;
                line = idx;
                rank = LW'(k);
            end
        end
    end
endmodule

// File: rtl/rotpic_top.sv
module rotpic_top
    import rotpic_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [DW-1:0]     ack_vec,
    input  logic              poll_rd,
    output logic [DW-1:0]     poll_data,
    output logic              int_out
);
    localparam int LW = $clog2(NLINES);
    localparam int BW = DW - LW;

    state_e            state_q, state_nx;
    cmd_t              cmd;
    logic [LW-1:0]     cmd_line;
    logic [NLINES-1:0] irr_q, mask_q, isr_q, trig_q;
    logic [LW-1:0]     off_q;
    logic [BW-1:0]     base_q;

    logic [NLINES-1:0] req_vec, req_oh, eoi_oh, irr_clr, isr_nx, mask_nx;
    logic              req_hit, isr_hit, pend_ok, take, poll_take, eoi_go;
    logic [LW-1:0]     req_line, req_rank, isr_line, isr_rank, eoi_line, off_nx;
    logic [BW-1:0]     base_nx;

    rotpic_cmd_dec #(.DW(DW), .LW(LW)) dec_i (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd      (cmd),
        .cmd_line (cmd_line)
    );

    rotpic_capture #(.NLINES(NLINES)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .level_sel (trig_q),
        .clr       (irr_clr),
        .flush     (cmd.init),
        .irr_q     (irr_q)
    );

    assign req_vec = irr_q & ~mask_q;

    rotpic_resolver #(.NLINES(NLINES), .LW(LW)) req_res_i (
        .vec      (req_vec),
        .base_off (off_q),
        .hit      (req_hit),
        .line     (req_line),
        .rank     (req_rank)
    );

    rotpic_resolver #(.NLINES(NLINES), .LW(LW)) isr_res_i (
        .vec      (isr_q),
        .base_off (off_q),
        .hit      (isr_hit),
        .line     (isr_line),
        .rank     (isr_rank)
    );

    // a request qualifies only if it outranks everything in service
    assign pend_ok   = req_hit && (!isr_hit || (req_rank < isr_rank));
    assign int_out   = pend_ok;
    assign req_oh    = NLINES'(1) << req_line;
    assign take      = ack_req && pend_ok;
    assign poll_take = poll_rd && pend_ok;

    assign eoi_line = cmd.eoi_spec ? cmd_line : isr_line;
    assign eoi_go   = cmd.eoi_spec || (cmd.eoi_ns && isr_hit);
    assign eoi_oh   = eoi_go ? (NLINES'(1) << eoi_line) : '0;

    assign irr_clr = (take ? (req_oh & ~trig_q) : '0) | (poll_take ? req_oh : '0);

    always_comb begin
        if (cmd.init) isr_nx = '0;
        else          isr_nx = (isr_q & ~eoi_oh & ~(poll_take ? req_oh : '0))
                               | (take ? req_oh : '0);

        if (cmd.init)                off_nx = '0;
        else if (cmd.set_pri)        off_nx = cmd_line + LW'(1);
        else if (eoi_go && cmd.rotate) off_nx = eoi_line + LW'(1);
        else                         off_nx = off_q;

        mask_nx = mask_q;
        base_nx = base_q;
        if (cmd.init)
            mask_nx = '0;
        else if (cmd.data && state_q == ST_RUN)
            mask_nx = wr_data[NLINES-1:0];
        else if (cmd.data && state_q == ST_WAIT_BASE)
            base_nx = wr_data[DW-1:LW];
    end

    // state transitions: T_INIT, T_REINIT, T_BASE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN:       if (cmd.init) state_nx = ST_WAIT_BASE;
            ST_WAIT_BASE: if (cmd.init)      state_nx = ST_WAIT_BASE;
                          else if (cmd.data) state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            isr_q     <= '0;
            trig_q    <= '0;
            off_q     <= '0;
            base_q    <= '0;
            ack_valid <= 1'b0;
            ack_vec   <= '0;
            poll_data <= '0;
        end else begin
            mask_q    <= mask_nx;
            isr_q     <= isr_nx;
            off_q     <= off_nx;
            base_q    <= base_nx;
            ack_valid <= ack_req;
            if (cmd.trig) trig_q <= wr_data[NLINES-1:0];
            if (ack_req)
                ack_vec <= pend_ok ? {base_q, req_line} : {base_q, LW'(NLINES - 1)};
            if (poll_rd)
                poll_data <= pend_ok ? ((DW'(1) << (DW - 1)) | DW'(req_line))
                                     : DW'(NLINES - 1);
        end
    end
endmodule

// File: rtl/rotpic_checker.sv
module rotpic_checker #(
    parameter int NLINES = 8,
    parameter int DW     = 8,
    parameter int LW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              ack_req,
    input logic              ack_valid,
    input logic [LW-1:0]     ack_low,
    input logic              poll_rd,
    input logic [DW-1:0]     poll_data,
    input logic              int_out,
    input logic [NLINES-1:0] irr_q,
    input logic [NLINES-1:0] mask_q,
    input logic [NLINES-1:0] isr_q
);
    a_r6_ack_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);

    a_r7_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ($past(int_out) || ack_low == LW'(NLINES - 1)));

    a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr_q & ~mask_q)));

    a_r12_poll_format: assert property (@(posedge clk) disable iff (!rst_n)
        poll_rd |=> (poll_data[DW-1] || poll_data == DW'(NLINES - 1)));

    a_r13_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[DW-4])
        |=> (isr_q == '0 && mask_q == '0 && !int_out));

    a_r8_seoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[DW-1:DW-5] == 5'b01100 && !ack_req)
        |=> (isr_q[$past(wr_data[LW-1:0])] == 1'b0));
endmodule

bind rotpic_top rotpic_checker #(.NLINES(NLINES), .DW(DW), .LW(LW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ack_req   (ack_req),
    .ack_valid (ack_valid),
    .ack_low   (ack_vec[LW-1:0]),
    .poll_rd   (poll_rd),
    .poll_data (poll_data),
    .int_out   (int_out),
    .irr_q     (irr_q),
    .mask_q    (mask_q),
    .isr_q     (isr_q)
);

// File: tb/rotpic_tb.sv
`timescale 1ns/1ps
module rotpic_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ack_req = 1'b0;
    logic       ack_valid;
    logic [7:0] ack_vec;
    logic       poll_rd = 1'b0;
    logic [7:0] poll_data;
    logic       int_out;

    int vectors = 0;
    int errs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rotpic_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack_req(ack_req),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .poll_rd(poll_rd),
        .poll_data(poll_data), .int_out(int_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] p);
        irq_in = p;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic ack(output logic [7:0] v, output logic vld);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        v = ack_vec; vld = ack_valid;
    endtask

    task automatic poll(output logic [7:0] v);
        poll_rd = 1'b1;
        @(negedge clk);
        poll_rd = 1'b0;
        v = poll_data;
    endtask

    function automatic logic [2:0] winner(input logic [7:0] p, input int off);
        for (int j = 0; j < 8; j++)
            if (p[(off + j) % 8]) return 3'((off + j) % 8);
        return 3'd7;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic vld;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 int", {7'd0, int_out}, 8'h00);
        chk("R1 ack_valid", {7'd0, ack_valid}, 8'h00);
        chk("R1 poll_data", poll_data, 8'h00);
        pulse(8'h81);
        ack(v, vld);
        chk("R1 offset0 base0 vec", v, 8'h00);
        wr(0, 8'h60);
        poll(v); chk("R1 R12 poll", v, 8'h87);
        poll(v); chk("R12 poll empty", v, 8'h07);

        // R13 init then base
        wr(0, 8'h10); wr(1, 8'h47);
        wr(1, 8'hFF);
        pulse(8'h08); chk("R4 masked", {7'd0, int_out}, 8'h00);
        wr(1, 8'h00); chk("R4 unmasked", {7'd0, int_out}, 8'h01);
        ack(v, vld); chk("R13 base vec", v, 8'h43);
        chk("R6 ack_valid", {7'd0, vld}, 8'h01);
        wr(0, 8'h63);
        wr(1, 8'hFF); pulse(8'h02);
        wr(0, 8'h10); chk("R13 irr flushed", {7'd0, int_out}, 8'h00);
        wr(1, 8'h9F);
        pulse(8'h02); chk("R13 mask cleared", {7'd0, int_out}, 8'h01);
        ack(v, vld); chk("R13 new base", v, 8'h99);
        wr(0, 8'h10); wr(1, 8'h40);
        pulse(8'h80); chk("R13 isr cleared", {7'd0, int_out}, 8'h01);
        poll(v); chk("R12 poll line7", v, 8'h87);

        // R7 spurious
        ack(v, vld); chk("R7 spurious vec", v, 8'h47);
        chk("R7 ack_valid", {7'd0, vld}, 8'h01);
        pulse(8'h80); chk("R7 isr untouched", {7'd0, int_out}, 8'h01);
        poll(v); chk("R12 drain", v, 8'h87);

        // R5 nesting, R10 plain non-specific
        pulse(8'h10); ack(v, vld); chk("R6 vec4", v, 8'h44);
        pulse(8'h40); chk("R5 lower blocked", {7'd0, int_out}, 8'h00);
        pulse(8'h02); chk("R5 higher passes", {7'd0, int_out}, 8'h01);
        ack(v, vld); chk("R5 nested vec", v, 8'h41);
        wr(0, 8'h20); chk("R10 ns clears top only", {7'd0, int_out}, 8'h00);
        wr(0, 8'h20); chk("R10 ns second", {7'd0, int_out}, 8'h01);
        poll(v); chk("R12 poll6", v, 8'h86);
        poll(v); chk("R12 empty", v, 8'h07);

        // R10 rotate non-specific
        pulse(8'h24); ack(v, vld); chk("R6 vec2", v, 8'h42);
        wr(0, 8'hA0); chk("R10 rotate int", {7'd0, int_out}, 8'h01);
        pulse(8'h02); ack(v, vld); chk("R10 offset3", v, 8'h45);
        wr(0, 8'h20);
        pulse(8'h50); ack(v, vld); chk("R10 plain no rotate", v, 8'h44);
        wr(0, 8'h10); wr(1, 8'h40);

        // R9 rotate specific
        pulse(8'h08); ack(v, vld); chk("R6 vec3", v, 8'h43);
        wr(0, 8'hE3);
        pulse(8'h44); ack(v, vld); chk("R9 offset4", v, 8'h46);
        wr(0, 8'h10); wr(1, 8'h40);

        // R14 R3 level mode
        wr(2, 8'h20);
        irq_in = 8'h20; idle();
        chk("R3 level int", {7'd0, int_out}, 8'h01);
        ack(v, vld); chk("R3 level vec", v, 8'h45);
        wr(0, 8'h65); chk("R3 irr kept", {7'd0, int_out}, 8'h01);
        irq_in = 8'h00; idle();
        chk("R3 follows low", {7'd0, int_out}, 8'h00);
        wr(0, 8'h10); wr(1, 8'h40);
        irq_in = 8'h20; idle();
        ack(v, vld); chk("R14 level vec", v, 8'h45);
        wr(0, 8'h65); chk("R13 R14 select kept", {7'd0, int_out}, 8'h01);
        irq_in = 8'h00; idle();
        chk("R3 drop", {7'd0, int_out}, 8'h00);
        wr(2, 8'h00);

        // R2 held edge
        irq_in = 8'h04; idle();
        chk("R2 edge int", {7'd0, int_out}, 8'h01);
        ack(v, vld); chk("R2 vec", v, 8'h42);
        wr(0, 8'h62); chk("R2 no retrigger", {7'd0, int_out}, 8'h00);
        irq_in = 8'h00; idle();

        // sweep offsets and patterns: R5 R6 R7 R8 R11 R12
        for (int off = 0; off < 8; off++) begin
            wr(0, 8'hC0 | 8'((off + 7) % 8));
            for (int k = 0; k < 16; k++) begin
                logic [7:0] pat, rem;
                logic [2:0] w;
                pat = (k == 0) ? 8'h00 : 8'((off * 37 + k * 53 + 11) & 8'hFF);
                w = winner(pat, off);
                pulse(pat);
                chk("R5 sweep int", {7'd0, int_out}, {7'd0, pat != 0});
                ack(v, vld);
                chk("R11 R6 R7 sweep vec", v, 8'h40 | 8'(w));
                if (pat != 0) begin
                    wr(0, 8'h60 | 8'(w));
                    rem = pat & ~(8'h01 << w);
                    for (int j = 0; j < 8; j++) begin
                        if (rem[(off + j) % 8]) begin
                            poll(v);
                            chk("R8 R12 sweep order", v, 8'h80 | 8'((off + j) % 8));
                        end
                    end
                    poll(v); chk("R12 sweep empty", v, 8'h07);
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule